// File: doc/BRIEF.md
# Display Controller Byte-Stream Decoder

This block sits behind the byte layer of a two-wire serial write port and turns the received stream into display-controller state and framebuffer writes. Every byte arrives with a one-cycle valid strobe, and a separate one-cycle pulse marks the end of a bus transaction. A prefix byte picks the role of what follows. After a command prefix, one command byte updates the column, page, start-line or display flags. After a data prefix, every following byte goes into a page-organised framebuffer of 132 columns by 8 pages through a simple write port.

The mode register has three named states. IDLE waits for a prefix: 0x80 takes the transition to CMD, 0x40 takes the transition to DATA, and any other byte raises a prefix error while the state stays in IDLE. CMD executes one command byte and then returns to IDLE. A command that carries a parameter returns to IDLE with a parameter-pending flag set. The next byte that reaches CMD is then swallowed, and the state stays in CMD, so the byte after it is decoded as a command without a new prefix. DATA holds until the transaction ends. The transaction-end pulse forces any state back to IDLE and does not touch the pending flag.

A scan-out block reads the framebuffer and the flag outputs. It acknowledges the redraw request after it refreshes the panel.

Top module: `oled_cmd_decoder`

## Requirements
- R1: After reset, col_addr and page_addr are 0, start_line is 0, mirror_en, all_on, inverse_en, disp_on, redraw, fb_we, prefix_err and cmd_err are all 0, the mode is IDLE and no parameter is pending.
- R2: In IDLE, 0x80 selects CMD and 0x40 selects DATA. Any other byte pulses prefix_err for one cycle, starting the cycle after the byte, and changes no other state.
- R3: In DATA, each byte with col_addr < 132 produces, in the next cycle, fb_we=1, fb_wdata equal to the byte and fb_addr = col_addr + 132*page_addr, and col_addr increments by one. With col_addr >= 132 the byte is dropped: no write, and col_addr is unchanged.
- R4: Command 0x00-0x0F replaces bits [3:0] of col_addr with the command's low nibble. Command 0x10-0x1F replaces bits [7:4] of col_addr with the command's low nibble.
- R5: Command 0xB0-0xBF sets page_addr to bits [2:0] of the command.
- R6: 0xA1/0xA0 set/clear mirror_en, 0xA5/0xA4 set/clear all_on, 0xA7/0xA6 set/clear inverse_en, and 0xAF/0xAE set/clear disp_on.
- R7: Commands 0x81, 0xA8, 0xAD, 0xD3, 0xD5, 0xD8, 0xD9, 0xDA and 0xDB set the parameter-pending flag. The next byte taken in CMD is discarded, and the decoder stays in CMD, so the byte after it is executed as a command.
- R8: After a command byte without pending parameter is executed, the decoder is in IDLE, and a further command needs a new 0x80 prefix.
- R9: A transaction-end pulse returns the decoder to IDLE from any state.
- R10: Command 0x40-0x7F sets start_line to 0 and raises no error.
- R11: Every framebuffer write sets redraw. redraw stays set until a cycle with redraw_ack=1 and no new write, after which it reads 0.
- R12: A command byte outside all listed ranges pulses cmd_err for one cycle and changes no state. 0xE3 and 0xC0-0xC8 change no state and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_valid | input | 1 | One-cycle strobe for byte_data |
| byte_data | input | 8 | Received byte |
| xfer_end | input | 1 | One-cycle transaction-end pulse |
| redraw_ack | input | 1 | Scan-out acknowledges the redraw request |
| fb_we | output | 1 | Framebuffer write enable |
| fb_addr | output | 11 | Framebuffer byte address, column + 132 * page |
| fb_wdata | output | 8 | Framebuffer write data |
| col_addr | output | 8 | Current column address |
| page_addr | output | 3 | Current page address |
| start_line | output | 6 | Display start line |
| mirror_en | output | 1 | Horizontal mirror flag |
| all_on | output | 1 | Entire-display-on flag |
| inverse_en | output | 1 | Inverse video flag |
| disp_on | output | 1 | Display enable flag |
| redraw | output | 1 | Framebuffer changed since last acknowledge |
| prefix_err | output | 1 | Pulse: bad prefix byte in IDLE |
| cmd_err | output | 1 | Pulse: unknown command byte |

## Verification
The properties assume that byte_valid and xfer_end are single-cycle strobes. They also assume that a byte never arrives in the same cycle as a transaction-end pulse, since such a byte would be decoded and then overridden by the forced return to IDLE. The driver tasks raise each strobe for exactly one cycle and keep them apart. redraw_ack is only raised while no data byte is being written, so the redraw hold property sees a clean acknowledge.

// File: rtl/oled_dec_pkg.sv
package oled_dec_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_CMD  = 2'd1,
        MODE_DATA = 2'd2
    } mode_e;

    typedef enum logic [3:0] {
        K_COL_LO,
        K_COL_HI,
        K_START,
        K_MIRROR,
        K_ALLON,
        K_INVERT,
        K_DISP,
        K_PAGE,
        K_PARAM,
        K_NOP,
        K_BAD
    } cmd_kind_e;

    localparam logic [7:0] PFX_CMD  = 8'h80;
    localparam logic [7:0] PFX_DATA = 8'h40;

endpackage

// File: rtl/oled_cmd_classify.sv
module oled_cmd_classify
    import oled_dec_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output cmd_kind_e  kind
);

    always_comb begin
        unique case (cmd_byte) inside
            [8'h00:8'h0F]:                 kind = K_COL_LO;
            [8'h10:8'h1F]:                 kind = K_COL_HI;
            [8'h40:8'h7F]:                 kind = K_START;
            [8'hB0:8'hBF]:                 kind = K_PAGE;
            8'hA0, 8'hA1:                  kind = K_MIRROR;
            8'hA4, 8'hA5:                  kind = K_ALLON;
            8'hA6, 8'hA7:                  kind = K_INVERT;
            8'hAE, 8'hAF:                  kind = K_DISP;
            8'h81, 8'hA8, 8'hAD, 8'hD3, 8'hD5,
            8'hD8, 8'hD9, 8'hDA, 8'hDB:    kind = K_PARAM;
            [8'hC0:8'hC8], 8'hE3:          kind = K_NOP;
            default:                       kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/oled_mode_fsm.sv
module oled_mode_fsm
    import oled_dec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       xfer_end,
    input  logic       param_pend,
    output mode_e      mode,
    output logic       prefix_err
);

    mode_e mode_d;

    always_comb begin
        mode_d = mode;
        if (byte_valid) begin
            unique case (mode)
                MODE_IDLE: begin
                    if (byte_data == PFX_CMD)
                        mode_d = MODE_CMD;
                    else if (byte_data == PFX_DATA)
                        mode_d = MODE_DATA;
                end
                MODE_CMD:  mode_d = param_pend ? MODE_CMD : MODE_IDLE;
                MODE_DATA: mode_d = MODE_DATA;
                default:   mode_d = MODE_IDLE;
            endcase
        end
        if (xfer_end)
            mode_d = MODE_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode <= MODE_IDLE;
        else
            mode <= mode_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prefix_err <= 1'b0;
        else
            prefix_err <= byte_valid && (mode == MODE_IDLE) &&
                          (byte_data != PFX_CMD) && (byte_data != PFX_DATA);
    end

endmodule

// File: rtl/oled_cmd_decoder.sv
module oled_cmd_decoder
    import oled_dec_pkg::*;
#(
    parameter int COLS  = 132,
    parameter int PAGES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       xfer_end,
    input  logic       redraw_ack,
    output logic       fb_we,
    output logic [$clog2(COLS*PAGES)-1:0] fb_addr,
    output logic [7:0] fb_wdata,
    output logic [7:0] col_addr,
    output logic [$clog2(PAGES)-1:0] page_addr,
    output logic [5:0] start_line,
    output logic       mirror_en,
    output logic       all_on,
    output logic       inverse_en,
    output logic       disp_on,
    output logic       redraw,
    output logic       prefix_err,
    output logic       cmd_err
);

    localparam int ADDR_W = $clog2(COLS*PAGES);
    localparam int PAGE_W = $clog2(PAGES);

    mode_e     mode_q;
    cmd_kind_e kind;
    logic      param_pend;
    logic      cmd_fire;
    logic      skip_fire;
    logic      data_fire;
    logic      wr_ok;

    oled_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .xfer_end   (xfer_end),
        .param_pend (param_pend),
        .mode       (mode_q),
        .prefix_err (prefix_err)
    );

    oled_cmd_classify u_cls (
        .cmd_byte (byte_data),
        .kind     (kind)
    );

    assign cmd_fire  = byte_valid && (mode_q == MODE_CMD) && !param_pend;
    assign skip_fire = byte_valid && (mode_q == MODE_CMD) &&  param_pend;
    assign data_fire = byte_valid && (mode_q == MODE_DATA);
    assign wr_ok     = data_fire && (col_addr < 8'(COLS));

    // Command execution and parameter tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_addr   <= '0;
            page_addr  <= '0;
            start_line <= '0;
            mirror_en  <= 1'b0;
            all_on     <= 1'b0;
            inverse_en <= 1'b0;
            disp_on    <= 1'b0;
            param_pend <= 1'b0;
            cmd_err    <= 1'b0;
        end else begin
            cmd_err <= 1'b0;
            if (skip_fire)
                param_pend <= 1'b0;
            if (wr_ok)
                col_addr <= col_addr + 8'd1;
            if (cmd_fire) begin
                unique case (kind)
                    K_COL_LO: col_addr[3:0] <= byte_data[3:0];
                    K_COL_HI: col_addr[7:4] <= byte_data[3:0];
                    K_START:  start_line    <= '0;
                    K_PAGE:   page_addr     <= byte_data[PAGE_W-1:0];
                    K_MIRROR: mirror_en     <= byte_data[0];
                    K_ALLON:  all_on        <= byte_data[0];
                    K_INVERT: inverse_en    <= byte_data[0];
                    K_DISP:   disp_on       <= byte_data[0];
                    K_PARAM:  param_pend    <= 1'b1;
                    K_NOP:    ;
                    K_BAD:    cmd_err       <= 1'b1;
                    default:  cmd_err       <= 1'b1;
                endcase
            end
        end
    end

    // Framebuffer write port and redraw request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fb_we    <= 1'b0;
            fb_addr  <= '0;
            fb_wdata <= '0;
            redraw   <= 1'b0;
        end else begin
            fb_we <= wr_ok;
            if (wr_ok) begin
                fb_addr  <= ADDR_W'(col_addr) + ADDR_W'(page_addr) * ADDR_W'(COLS);
                fb_wdata <= byte_data;
            end
            if (wr_ok)
                redraw <= 1'b1;
            else if (redraw_ack)
                redraw <= 1'b0;
        end
    end

endmodule

// File: rtl/oled_cmd_decoder_chk.sv
module oled_cmd_decoder_chk
    import oled_dec_pkg::*;
#(
    parameter int COLS  = 132,
    parameter int PAGES = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_valid,
    input logic       xfer_end,
    input logic       redraw_ack,
    input logic       fb_we,
    input logic [$clog2(COLS*PAGES)-1:0] fb_addr,
    input logic [7:0] col_addr,
    input logic       redraw,
    input logic       prefix_err,
    input logic       cmd_err,
    input mode_e      mode
);

    localparam int ADDR_W = $clog2(COLS*PAGES);

    // R3
    fb_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> (fb_addr < ADDR_W'(COLS*PAGES)));

    // R3
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && mode == MODE_DATA && col_addr < 8'(COLS))
        |=> (fb_we && col_addr == $past(col_addr) + 8'd1));

    // R3
    col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && mode == MODE_DATA && col_addr >= 8'(COLS))
        |=> (!fb_we && $stable(col_addr)));

    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_end |=> (mode == MODE_IDLE));

    // R2
    prefix_err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prefix_err |-> (mode == MODE_IDLE));

    // R11
    redraw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redraw && !redraw_ack) |=> redraw);

    // R11
    redraw_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> redraw);

    // R12
    cmd_err_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> ($stable(col_addr) && !fb_we));

endmodule

bind oled_cmd_decoder oled_cmd_decoder_chk #(.COLS(COLS), .PAGES(PAGES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .xfer_end   (xfer_end),
    .redraw_ack (redraw_ack),
    .fb_we      (fb_we),
    .fb_addr    (fb_addr),
    .col_addr   (col_addr),
    .redraw     (redraw),
    .prefix_err (prefix_err),
    .cmd_err    (cmd_err),
    .mode       (mode_q)
);

// File: tb/sim_oled_cmd_decoder.sv
module sim_oled_cmd_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int NCOL = 132;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       xfer_end = 1'b0;
    logic       redraw_ack = 1'b0;
    logic       fb_we;
    logic [10:0] fb_addr;
    logic [7:0] fb_wdata;
    logic [7:0] col_addr;
    logic [2:0] page_addr;
    logic [5:0] start_line;
    logic       mirror_en, all_on, inverse_en, disp_on, redraw;
    logic       prefix_err, cmd_err;

    int n_chk = 0;
    int n_fail = 0;
    int m_col = 0;
    int m_page = 0;
    logic [18:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    oled_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .xfer_end(xfer_end), .redraw_ack(redraw_ack), .fb_we(fb_we),
        .fb_addr(fb_addr), .fb_wdata(fb_wdata), .col_addr(col_addr),
        .page_addr(page_addr), .start_line(start_line), .mirror_en(mirror_en),
        .all_on(all_on), .inverse_en(inverse_en), .disp_on(disp_on),
        .redraw(redraw), .prefix_err(prefix_err), .cmd_err(cmd_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Monitor: compare every framebuffer write against the scoreboard
    always @(negedge clk) begin
        if (rst_n && fb_we) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R3: actual write addr %0d data 0x%0h expected none",
                         fb_addr, fb_wdata);
            end else begin
                logic [18:0] e;
                e = exp_q.pop_front();
                if ({fb_addr, fb_wdata} != e) begin
                    n_fail++;
                    $display("FAIL R3: actual addr %0d data 0x%0h expected addr %0d data 0x%0h",
                             fb_addr, fb_wdata, e[18:8], e[7:0]);
                end
            end
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b);
        send(8'h80);
        send(b);
    endtask

    task automatic data_byte(input logic [7:0] b);
        if (m_col < NCOL) begin
            exp_q.push_back({11'(m_col + m_page * NCOL), b});
            m_col++;
        end
        send(b);
    endtask

    task automatic stop();
        @(negedge clk);
        xfer_end = 1'b1;
        @(negedge clk);
        xfer_end = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 col", col_addr, 0);
        check("R1 page", page_addr, 0);
        check("R1 start", start_line, 0);
        check("R1 flags", {mirror_en, all_on, inverse_en, disp_on}, 0);
        check("R1 redraw", redraw, 0);
        check("R1 errs", {prefix_err, cmd_err, fb_we}, 0);

        // R3 R11 data burst at page 0
        send(8'h40);
        data_byte(8'hA5);
        data_byte(8'h5A);
        data_byte(8'h3C);
        check("R3 col after burst", col_addr, 3);
        check("R11 redraw set", redraw, 1);
        stop();
        @(negedge clk);
        redraw_ack = 1'b1;
        @(negedge clk);
        redraw_ack = 1'b0;
        check("R11 redraw cleared", redraw, 0);

        // R5 R4 addressing, then a write
        cmd(8'hB5);
        m_page = 5;
        check("R5 page", page_addr, 5);
        cmd(8'h02);
        check("R4 low nibble", col_addr, 8'h02);
        cmd(8'h17);
        check("R4 high nibble", col_addr, 8'h72);
        m_col = 8'h72;
        send(8'h40);
        data_byte(8'h11);
        check("R11 redraw after write", redraw, 1);
        stop();

        // R8 a command without a fresh prefix is a prefix error
        cmd(8'hAF);
        check("R6 disp on", disp_on, 1);
        send(8'hA7);
        check("R8 prefix error", prefix_err, 1);
        check("R8 inverse untouched", inverse_en, 0);
        @(negedge clk);
        check("R2 error is a pulse", prefix_err, 0);

        // R6 flags
        cmd(8'hA1); cmd(8'hA5); cmd(8'hA7);
        check("R6 set flags", {mirror_en, all_on, inverse_en}, 3'b111);
        cmd(8'hA0); cmd(8'hA4); cmd(8'hA6);
        check("R6 clear flags", {mirror_en, all_on, inverse_en}, 3'b000);
        cmd(8'hAE);
        check("R6 disp off", disp_on, 0);
        cmd(8'hAF);

        // R7 parameter skip, then command without prefix
        cmd(8'h81);
        check("R7 no error on param cmd", cmd_err, 0);
        send(8'h80);
        send(8'hA1);
        check("R7 parameter swallowed", mirror_en, 0);
        send(8'hA7);
        check("R7 stays in command mode", inverse_en, 1);
        check("R7 no prefix error", prefix_err, 0);
        cmd(8'hA6);

        // R12 unknown and no-op commands
        cmd(8'hFF);
        check("R12 cmd_err pulse", cmd_err, 1);
        check("R12 state kept", {col_addr, 5'(page_addr), mirror_en, all_on, inverse_en, disp_on},
              {8'h73, 5'd5, 4'b0001});
        cmd(8'hE3);
        check("R12 nop no error", cmd_err, 0);
        cmd(8'hC3);
        check("R12 nop state kept", {col_addr, 5'(page_addr), mirror_en, all_on, inverse_en, disp_on},
              {8'h73, 5'd5, 4'b0001});

        // R10 start line
        cmd(8'h45);
        check("R10 start line", start_line, 0);
        check("R10 no error", {cmd_err, prefix_err}, 0);

        // R3 column boundary at 131
        cmd(8'h03);
        cmd(8'h18);
        check("R4 col 131", col_addr, 131);
        m_col = 131;
        send(8'h40);
        data_byte(8'h77);
        data_byte(8'h88);
        check("R3 col stops at 132", col_addr, 132);

        // R9 stop returns to idle: next byte is a bad prefix, not data
        stop();
        send(8'h55);
        check("R9 idle after stop", prefix_err, 1);

        repeat (3) @(negedge clk);
        check("R3 all writes seen", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule